// File: doc/BRIEF.md
# Instruction Address Trap Unit

This block watches the prefetch address stream of a simple in-order processor and requests a trap interrupt when a programmed instruction address is fetched. The comparison is made as soon as the matching halfword is prefetched. The request itself is held back until an instruction boundary, so the core can stack a clean return address. The return address presented with the request is the sequential successor of the instruction that completed at that boundary.

Software programs a halfword-aligned trap address and a control register holding an enable bit. Setting the enable bit does not arm the comparator at once. Arming happens only after one more instruction has completed. If a taken branch completes while a trap is pending, the trap is not delivered on that branch. It is delivered after the first instruction at the branch target finishes. Clearing the enable bit drops any pending trap at once and restarts the arming delay.

Top module: `addr_trap_unit`

## Requirements
- R1: After the enable bit changes from 0 to 1, the comparator stays disarmed until a completion strobe (`done_valid`=1) is seen in a later cycle than the control write. A completion strobe in the same cycle as the write does not count. Prefetches during the disarmed window never cause a trap.
- R2: While armed, a cycle with `pf_valid`=1 and `pf_addr[15:1]` equal to the trap address bits [15:1] makes a trap pending. Bit 0 of `pf_addr` is ignored, and prefetches with `pf_valid`=0 are ignored.
- R3: A pending trap is delivered at the next completion strobe with `br_taken`=0. In the cycle after that clock edge, `irq` is 1 for exactly one cycle and `ret_addr` equals the `done_next` value of that strobe. `ret_addr` then holds that value. With no completion strobe, no request is raised however long the trap stays pending.
- R4: A completion strobe with `br_taken`=1 leaves a pending trap pending and raises no request. The trap is then delivered at the following non-branch completion.
- R5: Only one trap is pending at a time. Matches while a trap is pending, including one in the delivery cycle, are discarded, and two requests never occur in consecutive cycles.
- R6: Writing 0 to the enable bit cancels a pending trap in that same cycle, even if a completion strobe is present, and it disarms the comparator.
- R7: Register select 0 is the trap address. It is written from `cfg_wdata` and reads back with bit 0 forced to 0. Register select 1 is control, with enable in bit 0 and the other bits reading 0. `cfg_rdata` reflects `cfg_sel` combinationally.
- R8: After reset, `irq`=0, `ret_addr`=0, the trap address reads 0 and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_valid | input | 1 | Prefetch address is valid this cycle |
| pf_addr | input | 16 | Instruction prefetch address |
| done_valid | input | 1 | An instruction completed this cycle |
| done_next | input | 16 | Sequential successor address of the completed instruction |
| br_taken | input | 1 | The completed instruction was a taken branch |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 trap address, 1 control |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_sel` |
| irq | output | 1 | One-cycle trap interrupt request |
| ret_addr | output | 16 | Return address to stack for the trap |

## Verification
The bench targets the enable window. A design that arms at once would trap on the halfword fetched right after the control write, and one that counts a completion strobe in the write cycle would trap a cycle early. Taken-branch sequences catch a design that fires on the branch completion and stacks the wrong address, since the return value must be the target's successor. Repeat matches while pending and an odd prefetch address expose a double request or a lost match. A disable that lands together with a completion strobe must suppress the request, and a design that cancels only on the next cycle would leak it.

// File: rtl/addr_trap_unit.sv
module addr_trap_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_valid,
  input  logic [AW-1:0] pf_addr,
  input  logic          done_valid,
  input  logic [AW-1:0] done_next,
  input  logic          br_taken,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          irq,
  output logic [AW-1:0] ret_addr
);

  logic [AW-1:1] trap_q;
  logic          en_q, armed_q, pend_q, irq_q;
  logic [AW-1:0] ret_q;

  wire wr_trap = cfg_we & ~cfg_sel;
  wire wr_ctrl = cfg_we & cfg_sel;
  wire en_set  = wr_ctrl & cfg_wdata[0];
  wire en_clr  = wr_ctrl & ~cfg_wdata[0];
  wire hit     = armed_q & pf_valid & (pf_addr[AW-1:1] == trap_q);
  wire deliver = pend_q & done_valid & ~br_taken & ~en_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_trap) trap_q <= cfg_wdata[AW-1:1];
      if (wr_ctrl) en_q   <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed_q <= 1'b0;
    else if (en_clr || (en_set && !en_q)) armed_q <= 1'b0;
    else if (en_q && done_valid)         armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (en_clr)  pend_q <= 1'b0;
    else if (deliver) pend_q <= 1'b0;
    else if (hit)     pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ret_q <= '0;
    end else begin
      irq_q <= deliver;
      if (deliver) ret_q <= done_next;
    end
  end

  assign cfg_rdata = cfg_sel ? {{(AW-1){1'b0}}, en_q} : {trap_q, 1'b0};
  assign irq       = irq_q;
  assign ret_addr  = ret_q;

  AST_ARM_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(done_valid) && $past(en_q)); // R1
  AST_PEND_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(armed_q) && $past(pf_valid)); // R2
  AST_IRQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done_valid) && !$past(br_taken) && ret_addr == $past(done_next)); // R3
  AST_BRANCH_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && done_valid && br_taken && !en_clr |=> pend_q && !irq); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_DISABLE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !pend_q && !armed_q && !irq); // R6
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> en_q); // R6

endmodule

// File: tb/sim_addr_trap_unit.sv
module sim_addr_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_valid = 1'b0, done_valid = 1'b0, br_taken = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] pf_addr = '0, done_next = '0, cfg_wdata = '0;
  logic [15:0] cfg_rdata, ret_addr;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  addr_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .done_valid(done_valid), .done_next(done_next), .br_taken(br_taken),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .ret_addr(ret_addr)
  );

  // {req[3:0], pf_valid, pf_addr, done_valid, done_next, br_taken, exp_irq, exp_ret}
  localparam int NV = 14;
  localparam logic [55:0] VEC [NV] = '{
    {4'd1, 1'b1, 16'h029E, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R1 not yet armed
    {4'd1, 1'b0, 16'h0000, 1'b1, 16'h02A0, 1'b0, 1'b0, 16'h0000}, // R1 arming completion
    {4'd2, 1'b1, 16'h029E, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2 match
    {4'd4, 1'b0, 16'h0000, 1'b1, 16'h02A8, 1'b1, 1'b0, 16'h0000}, // R4 taken branch
    {4'd4, 1'b1, 16'h02A6, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R4 target fetch
    {4'd4, 1'b0, 16'h0000, 1'b1, 16'h02A8, 1'b0, 1'b1, 16'h02A8}, // R4 delivered after target
    {4'd3, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R3 pulse ends
    {4'd2, 1'b1, 16'h029F, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2 bit0 ignored
    {4'd5, 1'b1, 16'h029E, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R5 repeat while pending
    {4'd3, 1'b0, 16'h0000, 1'b1, 16'h02A0, 1'b0, 1'b1, 16'h02A0}, // R3 delivery
    {4'd5, 1'b0, 16'h0000, 1'b1, 16'h02A2, 1'b0, 1'b0, 16'h0000}, // R5 no second trap
    {4'd2, 1'b1, 16'h02A0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2 other address
    {4'd2, 1'b0, 16'h029E, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2 strobe low
    {4'd2, 1'b0, 16'h0000, 1'b1, 16'h02A4, 1'b0, 1'b0, 16'h0000}  // R2 nothing pending
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic pv, input logic [15:0] pa, input logic dv, input logic [15:0] dn,
                     input logic br, input logic we, input logic sel, input logic [15:0] wd);
    pf_valid = pv; pf_addr = pa; done_valid = dv; done_next = dn; br_taken = br;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    pf_valid = 1'b0; done_valid = 1'b0; br_taken = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(irq == 1'b0, "R8 irq", {15'b0, irq}, 16'h0);
    chk(ret_addr == 16'h0, "R8 ret", ret_addr, 16'h0);
    cfg_sel = 1'b0; #0.1;
    chk(cfg_rdata == 16'h0, "R8 trap", cfg_rdata, 16'h0);
    cfg_sel = 1'b1; #0.1;
    chk(cfg_rdata == 16'h0, "R8 ctrl", cfg_rdata, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 register access
    cyc(0, 0, 0, 0, 0, 1, 0, 16'h1235);
    cfg_sel = 1'b0; #0.1;
    chk(cfg_rdata == 16'h1234, "R7 trap", cfg_rdata, 16'h1234);
    cyc(0, 0, 0, 0, 0, 1, 1, 16'hFFF2);
    cfg_sel = 1'b1; #0.1;
    chk(cfg_rdata == 16'h0000, "R7 ctrl0", cfg_rdata, 16'h0000);

    cyc(0, 0, 0, 0, 0, 1, 0, 16'h029E);
    cyc(0, 0, 0, 0, 0, 1, 1, 16'h0003);
    cfg_sel = 1'b1; #0.1;
    chk(cfg_rdata == 16'h0001, "R7 ctrl1", cfg_rdata, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      cyc(v[51], v[50:35], v[34], v[33:18], v[17], 0, 0, 0);
      chk(irq == v[16], $sformatf("R%0d vec%0d irq", v[55:52], i), {15'b0, irq}, {15'b0, v[16]});
      if (v[16])
        chk(ret_addr == v[15:0], $sformatf("R%0d vec%0d ret", v[55:52], i), ret_addr, v[15:0]);
    end
    chk(ret_addr == 16'h02A0, "R3 ret held", ret_addr, 16'h02A0);

    // R6 disable with a completion in the same cycle cancels
    cyc(1, 16'h029E, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 16'h0300, 0, 1, 1, 16'h0000);
    chk(irq == 1'b0, "R6 cancel", {15'b0, irq}, 16'h0);
    cyc(0, 0, 1, 16'h0302, 0, 0, 0, 0);
    chk(irq == 1'b0, "R6 stays clear", {15'b0, irq}, 16'h0);
    // R6 re-enable restarts the arming delay
    cyc(0, 0, 0, 0, 0, 1, 1, 16'h0001);
    cyc(1, 16'h029E, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 16'h0304, 0, 0, 0, 0);
    chk(irq == 1'b0, "R6 rearm window", {15'b0, irq}, 16'h0);

    // R1 completion in the enabling write cycle does not arm
    cyc(0, 0, 0, 0, 0, 1, 1, 16'h0000);
    cyc(0, 0, 1, 16'h0306, 0, 1, 1, 16'h0001);
    cyc(1, 16'h029E, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 16'h0308, 0, 0, 0, 0);
    chk(irq == 1'b0, "R1 same-cycle completion", {15'b0, irq}, 16'h0);
    // R3 pending waits for a completion
    cyc(1, 16'h029E, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      chk(irq == 1'b0, "R3 waits", {15'b0, irq}, 16'h0);
    end
    cyc(1, 16'h029E, 1, 16'h030A, 0, 0, 0, 0);
    chk(irq == 1'b1 && ret_addr == 16'h030A, "R3 late delivery", ret_addr, 16'h030A);
    // R5 match in the delivery cycle is discarded
    cyc(0, 0, 1, 16'h030C, 0, 0, 0, 0);
    chk(irq == 1'b0, "R5 delivery-cycle match", {15'b0, irq}, 16'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule